// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This unit carries out one step of a non-restoring binary division each cycle that its step enable is high. It holds a partial remainder register and three status bits: Q, which tracks the sign of the running remainder, M, which holds the divisor sign, and T, which carries one bit into the remainder at each step and holds the quotient bit the step produced.

A step shifts the remainder left by one and moves T into bit 0. It then subtracts the divisor when the previous Q equals M, or adds it otherwise. Q is rebuilt from the bit shifted out, the carry or borrow of that add or subtract, and M. T becomes 1 when the new Q equals M.

A separate init operation prepares Q, M and T in one of two ways. In unsigned mode it clears all three. In signed mode it takes Q and M from the sign bits of the dividend and divisor and sets T to their XOR. A controller outside the block loads the remainder and T through write ports, issues the steps, and gathers quotient bits by rotating a word through T.

Top module: `divstep_unit`

## Requirements
- R1: While rst_ni is low, rem_o, q_o, m_o and t_o are all zero.
- R2: An init with signed_i low clears Q, M and T on the next edge and leaves the remainder unchanged.
- R3: An init with signed_i high sets Q to data_i bit 31, M to divisor_i bit 31, and T to Q XOR M on the next edge. The remainder is unchanged.
- R4: A step first forms S = {rem[30:0], T}. It writes S - divisor to the remainder when the old Q equals M, and S + divisor otherwise, both modulo 2^32.
- R5: After a step, Q equals old rem[31] XOR c XOR M. Here c is the borrow of the subtract or the carry of the add, taken as the unsigned 32-bit wrap.
- R6: After a step, T is 1 exactly when the new Q equals M, and M keeps its value.
- R7: In a cycle with no init, step or write asserted, the remainder, Q, M and T all keep their values.
- R8: wr_rem_i loads data_i into the remainder, and wr_t_i loads t_d_i into T.
- R9: Init has priority over step, and step has priority over the writes. When init_i is high, step_i, wr_rem_i and wr_t_i have no effect. When step_i is high, wr_rem_i and wr_t_i have no effect.
- R10: The controller runs this sequence: unsigned init, remainder cleared, then 32 rounds of a rotate through T followed by a step, then one final rotate. For any dividend and any divisor from 1 to 2^31-1, the rotated word then equals the unsigned quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Init operation for Q, M and T |
| signed_i | input | 1 | Init mode: 1 selects signed, 0 selects unsigned |
| step_i | input | 1 | Perform one division step |
| wr_rem_i | input | 1 | Write data_i into the remainder |
| wr_t_i | input | 1 | Write t_d_i into T |
| t_d_i | input | 1 | Value written into T |
| data_i | input | 32 | Remainder write data; its bit 31 is the dividend sign for a signed init |
| divisor_i | input | 32 | Divisor |
| rem_o | output | 32 | Partial remainder |
| q_o | output | 1 | Q status bit |
| m_o | output | 1 | M status bit |
| t_o | output | 1 | T status bit |

## Verification
The assertions assume that divisor_i holds its value across a step, since the remainder check compares the result with the divisor sampled at the step edge. They also assume that controls asserted together follow the stated priority rather than combining. The bench drives every input at the falling edge and holds it through the next rising edge. It asserts the controls one at a time, except in the cases that deliberately test priority. Random steps reach all four Q/M pairs through signed inits on random data. Divisions keep the divisor nonzero and below 2^31.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } divstep_flags_t;
endpackage

// File: rtl/divstep_alu.sv
module divstep_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic         q_i,
  input  logic         m_i,
  input  logic         t_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         t_o
);
  localparam int unsigned EW = W + 1;

  logic [W-1:0]  shifted;
  logic [EW-1:0] wide;
  logic          do_sub;
  logic          wrap;

  always_comb begin
    shifted = {rem_i[W-2:0], t_i};
    do_sub  = (q_i == m_i);
    if (do_sub) wide = {1'b0, shifted} - {1'b0, divisor_i};
    else        wide = {1'b0, shifted} + {1'b0, divisor_i};
    wrap  = wide[W];
    rem_o = wide[W-1:0];
    q_o   = rem_i[W-1] ^ wrap ^ m_i;
    t_o   = (q_o == m_i);
  end
endmodule

// File: rtl/divstep_init.sv
module divstep_init
  import divstep_pkg::*;
(
  input  logic           signed_i,
  input  logic           num_msb_i,
  input  logic           den_msb_i,
  output divstep_flags_t flags_o
);
  always_comb begin
    if (signed_i) begin
      flags_o.q = num_msb_i;
      flags_o.m = den_msb_i;
      flags_o.t = num_msb_i ^ den_msb_i;
    end else begin
      flags_o = '0;
    end
  end
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         signed_i,
  input  logic         step_i,
  input  logic         wr_rem_i,
  input  logic         wr_t_i,
  input  logic         t_d_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o
);
  logic [W-1:0]   rem_q;
  divstep_flags_t flg_q;
  divstep_flags_t init_flags;
  logic [W-1:0]   step_rem;
  logic           step_q;
  logic           step_t;

  divstep_init u_init (
    .signed_i  (signed_i),
    .num_msb_i (data_i[W-1]),
    .den_msb_i (divisor_i[W-1]),
    .flags_o   (init_flags)
  );

  divstep_alu #(.W(W)) u_alu (
    .rem_i     (rem_q),
    .q_i       (flg_q.q),
    .m_i       (flg_q.m),
    .t_i       (flg_q.t),
    .divisor_i (divisor_i),
    .rem_o     (step_rem),
    .q_o       (step_q),
    .t_o       (step_t)
  );

  // priority: init > step > register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      flg_q <= '0;
    end else if (init_i) begin
      flg_q <= init_flags;
    end else if (step_i) begin
      rem_q   <= step_rem;
      flg_q.q <= step_q;
      flg_q.t <= step_t;
    end else begin
      if (wr_rem_i) rem_q   <= data_i;
      if (wr_t_i)   flg_q.t <= t_d_i;
    end
  end

  assign rem_o = rem_q;
  assign q_o   = flg_q.q;
  assign m_o   = flg_q.m;
  assign t_o   = flg_q.t;
endmodule

// File: rtl/divstep_unit_chk.sv
module divstep_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         init_i,
  input logic         signed_i,
  input logic         step_i,
  input logic         wr_rem_i,
  input logic         wr_t_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] rem_o,
  input logic         q_o,
  input logic         m_o,
  input logic         t_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (rem_o == '0 && !q_o && !m_o && !t_o)); // R1

  AST_INIT_UNSIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && !signed_i |=> (!q_o && !m_o && !t_o && $stable(rem_o))); // R2

  AST_INIT_SIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && signed_i |=> (q_o == $past(data_i[W-1]) && m_o == $past(divisor_i[W-1])
                            && t_o == (q_o ^ m_o))); // R3

  AST_STEP_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !init_i && (q_o == m_o) |=>
      rem_o == ({$past(rem_o[W-2:0]), $past(t_o)} - $past(divisor_i))); // R4

  AST_STEP_T_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !init_i |=> (t_o == (q_o == m_o)) && $stable(m_o)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i && !step_i && !wr_rem_i && !wr_t_i |=>
      $stable(rem_o) && $stable(q_o) && $stable(m_o) && $stable(t_o)); // R7
endmodule

bind divstep_unit divstep_unit_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .init_i    (init_i),
  .signed_i  (signed_i),
  .step_i    (step_i),
  .wr_rem_i  (wr_rem_i),
  .wr_t_i    (wr_t_i),
  .data_i    (data_i),
  .divisor_i (divisor_i),
  .rem_o     (rem_o),
  .q_o       (q_o),
  .m_o       (m_o),
  .t_o       (t_o)
);

// File: tb/divstep_unit_tb.sv
`timescale 1ns/1ps
module divstep_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0, signed_i = 1'b0, step_i = 1'b0;
  logic        wr_rem_i = 1'b0, wr_t_i = 1'b0, t_d_i = 1'b0;
  logic [31:0] data_i = '0, divisor_i = '0;
  logic [31:0] rem_o;
  logic        q_o, m_o, t_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  divstep_unit u_dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    init_i = 0; step_i = 0; wr_rem_i = 0; wr_t_i = 0;
  endtask

  task automatic do_init(input bit sg, input logic [31:0] num, input logic [31:0] den);
    init_i = 1; signed_i = sg; data_i = num; divisor_i = den; tick();
  endtask

  task automatic do_wr(input logic [31:0] r, input bit t);
    wr_rem_i = 1; data_i = r; wr_t_i = 1; t_d_i = t; tick();
  endtask

  // expected step result from the requirements (R4, R5, R6)
  task automatic ref_step(input logic [31:0] r, input bit q, input bit m, input bit t,
                          input logic [31:0] d, output logic [31:0] nr, output bit nq, output bit nt);
    longint unsigned s, dd, res;
    bit c;
    s  = {32'h0, r[30:0], t};
    dd = {32'h0, d};
    if (q == m) begin c = (s < dd); res = s - dd; end
    else        begin res = s + dd; c = (res > 64'hFFFF_FFFF); end
    nr = res[31:0];
    nq = r[31] ^ c ^ m;
    nt = (nq == m);
  endtask

  task automatic run_step_check(input logic [31:0] r, input logic [31:0] num,
                                input logic [31:0] d, input bit t);
    logic [31:0] er; bit eq, et;
    do_init(1, num, d);
    do_wr(r, t);
    ref_step(r, num[31], d[31], t, d, er, eq, et);
    step_i = 1; divisor_i = d; tick();
    check(rem_o == er, "R4 rem", rem_o, er);
    check(q_o == eq, "R5 q", q_o, eq);
    check(t_o == et && m_o == d[31], "R6 t/m", {t_o, m_o}, {et, d[31]});
  endtask

  task automatic run_div(input logic [31:0] num, input logic [31:0] d);
    logic [31:0] lo; bit nt;
    divisor_i = d;
    do_init(0, 32'h0, d);
    wr_rem_i = 1; data_i = 32'h0; tick();
    lo = num;
    for (int i = 0; i < 32; i++) begin
      nt = lo[31];
      lo = {lo[30:0], t_o};
      wr_t_i = 1; t_d_i = nt; tick();
      step_i = 1; tick();
    end
    lo = {lo[30:0], t_o};
    check(lo == num / d, "R10 quotient", lo, num / d);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0; bit q0, t0;
    void'($urandom(32'h5eed_0001));
    repeat (3) @(negedge clk_i);
    check(rem_o == 0 && !q_o && !m_o && !t_o, "R1 reset", {rem_o, q_o, m_o, t_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R8 writes
    do_wr(32'hDEAD_BEEF, 1);
    check(rem_o == 32'hDEAD_BEEF && t_o, "R8 write", {rem_o, t_o}, {32'hDEAD_BEEF, 1'b1});

    // R3 signed init, all sign combos
    for (int k = 0; k < 4; k++) begin
      do_init(1, {k[1], 31'h123}, {k[0], 31'h456});
      check(q_o == k[1] && m_o == k[0] && t_o == (k[1] ^ k[0]) && rem_o == 32'hDEAD_BEEF,
            "R3 signed init", {q_o, m_o, t_o}, {k[1], k[0], k[1] ^ k[0]});
    end

    // R2 unsigned init
    do_init(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check(!q_o && !m_o && !t_o && rem_o == 32'hDEAD_BEEF, "R2 unsigned init",
          {q_o, m_o, t_o}, 0);

    // R7 idle hold
    do_init(1, 32'h8000_0000, 32'h0);
    data_i = $urandom; divisor_i = $urandom; t_d_i = 0; signed_i = 0;
    repeat (3) tick();
    check(rem_o == 32'hDEAD_BEEF && q_o && !m_o && t_o, "R7 hold", {rem_o, q_o, m_o, t_o},
          {32'hDEAD_BEEF, 3'b101});

    // R9 init blocks step and writes
    init_i = 1; signed_i = 0; step_i = 1; wr_rem_i = 1; wr_t_i = 1; t_d_i = 1;
    data_i = 32'h1111_1111; divisor_i = 32'h3; tick();
    check(rem_o == 32'hDEAD_BEEF && !t_o && !q_o, "R9 init priority", {rem_o, t_o}, {32'hDEAD_BEEF, 1'b0});

    // R9 step blocks writes: q=m=0,t=0, rem=DEADBEEF, d=3
    ref_step(32'hDEAD_BEEF, 0, 0, 0, 32'h3, r0, q0, t0);
    step_i = 1; wr_rem_i = 1; wr_t_i = 1; t_d_i = ~t0; data_i = 32'h2222_2222; tick();
    check(rem_o == r0 && t_o == t0, "R9 step priority", {rem_o, t_o}, {r0, t0});

    // directed corners for R4/R5/R6
    run_step_check(32'h0, 32'h0, 32'h1, 0);              // borrow, sub
    run_step_check(32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 1); // add, q!=m
    run_step_check(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 0); // sub, q=m=1
    run_step_check(32'h7FFF_FFFF, 32'h0, 32'hFFFF_FFFF, 1); // add with carry
    for (int i = 0; i < 60; i++)
      run_step_check($urandom, $urandom, $urandom, 1'($urandom));

    // R10 divisions
    run_div(32'h0, 32'h1);
    run_div(32'hFFFF_FFFF, 32'h1);
    run_div(32'hFFFF_FFFF, 32'h7FFF_FFFF);
    run_div(32'h1234_5678, 32'h1234_5679);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = $urandom & 32'h7FFF_FFFF;
      if (i % 3 == 0) d = d >> ($urandom % 28);
      if (d == 0) d = 1;
      run_div($urandom, d);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule